// File: doc/BRIEF.md
# Register Window Overflow Controller

This block tracks the windowed register file of a small soft processor. The file is split into equal frames, and a current-window pointer selects the active frame. A call moves the pointer down one frame and a return moves it back up. A resident-frame counter and a spilled-frame counter record how much of the call stack sits in the file and how much sits in memory.

When a call arrives and the file is already holding its maximum number of live frames, the block asks the memory side to write out exactly one frame, the oldest one. It does not flush the whole file. When a return reaches the bottom resident frame and older frames are still in memory, the block asks for one frame to be reloaded. A task switch uses a separate drain path. The drain writes out every live frame, oldest first, and then reports the depth of the task. A later switch-in takes a depth, reloads the active frame and leaves the rest in memory. Normal returns bring those frames back one at a time.

Every transfer is a request held until a one-cycle done pulse arrives. While a request is pending the block stalls, and call and return strobes are ignored.

Top module: `rwin_ctrl`

## Requirements
- R1: After synchronous reset the pointer is 0 and one frame is resident with none in memory. No request is raised, stall is low and saved_valid is low.
- R2: A call accepted with fewer than 15 frames resident lowers the pointer by one (mod 16) on the next cycle. A return with more than one frame resident raises it by one.
- R3: Starting from reset, 14 calls in a row raise no spill request.
- R4: A call arriving while 15 frames are resident raises spill_req with frame index pointer+14 (mod 16), which is the oldest frame. After the done pulse the pointer lowers by one and one more frame is counted in memory.
- R5: A return with one frame resident and at least one frame in memory raises fill_req with frame index pointer+1 (mod 16). After the done pulse the pointer rises by one.
- R6: stall is high exactly while a spill or fill request is pending. A request holds until done. Call and return strobes seen while stalled have no effect.
- R7: A return with one frame resident and none in memory has no effect.
- R8: A switch-out strobe while running drains all resident frames, one per done pulse. The first frame index is pointer+resident-1 and the last is the pointer itself. Switch-out takes priority over a call in the same cycle.
- R9: After the last drain transfer, saved_valid is high and saved_depth equals resident plus in-memory frames at the time of the switch. Calls and returns have no effect while parked.
- R10: A switch-in with depth D while parked raises fill_req for the pointer's own frame. After done, the block runs with one frame resident and D-1 frames in memory. A depth of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| switch_out_i | input | 1 | Task switch-out strobe, drains all frames |
| switch_in_i | input | 1 | Task switch-in strobe |
| restore_depth_i | input | DEPTH_W | Depth of the incoming task, sampled with switch_in_i |
| xfer_done_i | input | 1 | One-cycle pulse that ends the pending spill or fill |
| cwp_o | output | PTR_W | Current window pointer |
| spill_req_o | output | 1 | Request to write one frame to memory |
| fill_req_o | output | 1 | Request to load one frame from memory |
| xfer_frame_o | output | PTR_W | Frame index of the pending spill or fill |
| stall_o | output | 1 | Processor must hold while high |
| saved_valid_o | output | 1 | Drain complete, task parked |
| saved_depth_o | output | DEPTH_W | Depth of the parked task |

## Verification
The assertions assume that xfer_done_i is pulsed only while a request is pending. They also assume that the total call depth never exceeds what the DEPTH_W-bit memory counter can hold, and that switch-in is only meaningful after a drain has parked the block. The stimulus issues each done pulse only after it has seen a request at the ports. It keeps nesting below 20 frames and issues switch-in only after saved_valid has been observed. Strobes that arrive while the block is stalled or parked are driven on purpose, to show that they are ignored.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    // default geometry
    localparam int DEF_NUM_REGS   = 256;
    localparam int DEF_FRAME_REGS = 16;
    localparam int DEF_DEPTH_W    = 8;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,  // accepting call / return
        ST_OVF   = 3'd1,  // single-frame spill on overflow
        ST_UNF   = 3'd2,  // single-frame fill on underflow
        ST_DRAIN = 3'd3,  // task switch: spilling all frames
        ST_PARK  = 3'd4,  // drained, waiting for switch-in
        ST_LOAD  = 3'd5   // switch-in: reloading active frame
    } rwin_state_e;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_PUSH      = 3'd1,  // pointer down, one more resident
        OP_PUSH_ROLL = 3'd2,  // pointer down, oldest moved to memory
        OP_POP       = 3'd3,  // pointer up, one less resident
        OP_POP_FILL  = 3'd4,  // pointer up, one frame back from memory
        OP_EVICT     = 3'd5,  // drain step: resident to memory
        OP_LOAD      = 3'd6   // switch-in: reseed counters
    } rwin_op_e;

    typedef struct packed {
        logic full;       // resident count at its ceiling
        logic single;     // exactly one frame resident
        logic mem_empty;  // nothing held in memory
    } rwin_flags_t;

endpackage

// File: rtl/rwin_track.sv
module rwin_track
    import rwin_pkg::*;
#(
    parameter int PTR_W   = 4,
    parameter int RES_W   = 5,
    parameter int DEPTH_W = 8,
    parameter int MAX_RES = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  rwin_op_e           op,
    input  logic [DEPTH_W-1:0] load_depth,
    output logic [PTR_W-1:0]   cwp,
    output logic [RES_W-1:0]   res_cnt,
    output logic [DEPTH_W-1:0] mem_cnt,
    output rwin_flags_t        flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp     <= '0;
            res_cnt <= RES_W'(1);
            mem_cnt <= '0;
        end else begin
            case (op)
                OP_PUSH: begin
                    cwp     <= cwp - PTR_W'(1);
                    res_cnt <= res_cnt + RES_W'(1);
                end
                OP_PUSH_ROLL: begin
                    cwp     <= cwp - PTR_W'(1);
                    mem_cnt <= mem_cnt + DEPTH_W'(1);
                end
                OP_POP: begin
                    cwp     <= cwp + PTR_W'(1);
                    res_cnt <= res_cnt - RES_W'(1);
                end
                OP_POP_FILL: begin
                    cwp     <= cwp + PTR_W'(1);
                    mem_cnt <= mem_cnt - DEPTH_W'(1);
                end
                OP_EVICT: begin
                    res_cnt <= res_cnt - RES_W'(1);
                    mem_cnt <= mem_cnt + DEPTH_W'(1);
                end
                OP_LOAD: begin
                    res_cnt <= RES_W'(1);
                    mem_cnt <= (load_depth == '0) ? '0 : load_depth - DEPTH_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        flags.full      = (res_cnt == RES_W'(MAX_RES));
        flags.single    = (res_cnt == RES_W'(1));
        flags.mem_empty = (mem_cnt == '0);
    end

endmodule

// File: rtl/rwin_seq.sv
module rwin_seq
    import rwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        call,
    input  logic        ret,
    input  logic        sw_out,
    input  logic        sw_in,
    input  logic        done,
    input  rwin_flags_t flags,
    output rwin_state_e state,
    output rwin_op_e    op
);

    rwin_state_e nxt;

    always_comb begin
        nxt = state;
        op  = OP_NONE;
        case (state)
            ST_RUN: begin
                if (sw_out) begin
                    nxt = ST_DRAIN;
                end else if (call) begin
                    if (flags.full) nxt = ST_OVF;
                    else            op  = OP_PUSH;
                end else if (ret) begin
                    if (!flags.single)        op  = OP_POP;
                    else if (!flags.mem_empty) nxt = ST_UNF;
                end
            end
            ST_OVF: if (done) begin
                op  = OP_PUSH_ROLL;
                nxt = ST_RUN;
            end
            ST_UNF: if (done) begin
                op  = OP_POP_FILL;
                nxt = ST_RUN;
            end
            ST_DRAIN: if (done) begin
                op = OP_EVICT;
                if (flags.single) nxt = ST_PARK;
            end
            ST_PARK: if (sw_in) begin
                op  = OP_LOAD;
                nxt = ST_LOAD;
            end
            ST_LOAD: if (done) nxt = ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= nxt;
    end

endmodule

// File: rtl/rwin_frame_sel.sv
module rwin_frame_sel
    import rwin_pkg::*;
#(
    parameter int PTR_W = 4,
    parameter int RES_W = 5
) (
    input  rwin_state_e      state,
    input  logic [PTR_W-1:0] cwp,
    input  logic [RES_W-1:0] res_cnt,
    output logic [PTR_W-1:0] frame,
    output logic             spill_req,
    output logic             fill_req
);

    logic [PTR_W-1:0] oldest;

    always_comb begin
        oldest    = cwp + PTR_W'(res_cnt - RES_W'(1));
        spill_req = (state == ST_OVF) || (state == ST_DRAIN);
        fill_req  = (state == ST_UNF) || (state == ST_LOAD);
        case (state)
            ST_OVF, ST_DRAIN: frame = oldest;
            ST_UNF:           frame = cwp + PTR_W'(1);
            default:          frame = cwp;
        endcase
    end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NUM_REGS   = DEF_NUM_REGS,
    parameter int FRAME_REGS = DEF_FRAME_REGS,
    parameter int DEPTH_W    = DEF_DEPTH_W,
    localparam int NUM_FRAMES = NUM_REGS / FRAME_REGS,
    localparam int PTR_W      = $clog2(NUM_FRAMES),
    localparam int RES_W      = $clog2(NUM_FRAMES + 1),
    localparam int MAX_RES    = NUM_FRAMES - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               call_i,
    input  logic               ret_i,
    input  logic               switch_out_i,
    input  logic               switch_in_i,
    input  logic [DEPTH_W-1:0] restore_depth_i,
    input  logic               xfer_done_i,
    output logic [PTR_W-1:0]   cwp_o,
    output logic               spill_req_o,
    output logic               fill_req_o,
    output logic [PTR_W-1:0]   xfer_frame_o,
    output logic               stall_o,
    output logic               saved_valid_o,
    output logic [DEPTH_W-1:0] saved_depth_o
);

    rwin_state_e        state;
    rwin_op_e           op;
    rwin_flags_t        flags;
    logic [RES_W-1:0]   res_cnt;
    logic [DEPTH_W-1:0] mem_cnt;

    rwin_seq seq_i (
        .clk    (clk),
        .rst    (rst),
        .call   (call_i),
        .ret    (ret_i),
        .sw_out (switch_out_i),
        .sw_in  (switch_in_i),
        .done   (xfer_done_i),
        .flags  (flags),
        .state  (state),
        .op     (op)
    );

    rwin_track #(
        .PTR_W   (PTR_W),
        .RES_W   (RES_W),
        .DEPTH_W (DEPTH_W),
        .MAX_RES (MAX_RES)
    ) track_i (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .load_depth (restore_depth_i),
        .cwp        (cwp_o),
        .res_cnt    (res_cnt),
        .mem_cnt    (mem_cnt),
        .flags      (flags)
    );

    rwin_frame_sel #(
        .PTR_W (PTR_W),
        .RES_W (RES_W)
    ) sel_i (
        .state     (state),
        .cwp       (cwp_o),
        .res_cnt   (res_cnt),
        .frame     (xfer_frame_o),
        .spill_req (spill_req_o),
        .fill_req  (fill_req_o)
    );

    assign stall_o       = spill_req_o | fill_req_o;
    assign saved_valid_o = (state == ST_PARK);
    assign saved_depth_o = mem_cnt;

endmodule

// File: rtl/rwin_ctrl_chk.sv
module rwin_ctrl_chk #(
    parameter int PTR_W   = 4,
    parameter int RES_W   = 5,
    parameter int MAX_RES = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             call_i,
    input logic             switch_out_i,
    input logic             xfer_done_i,
    input logic [PTR_W-1:0] cwp_o,
    input logic             spill_req_o,
    input logic             fill_req_o,
    input logic [PTR_W-1:0] xfer_frame_o,
    input logic             stall_o,
    input logic             saved_valid_o,
    input logic [RES_W-1:0] res_cnt
);

    // R2: an accepted non-overflow call lowers the pointer by one
    a_r2_call_steps_down: assert property (@(posedge clk) disable iff (rst)
        (!stall_o && !saved_valid_o && call_i && !switch_out_i && res_cnt < RES_W'(MAX_RES))
        |=> (cwp_o == $past(cwp_o) - PTR_W'(1)));

    // R3: resident count never passes its ceiling
    a_r3_resident_bound: assert property (@(posedge clk) disable iff (rst)
        res_cnt <= RES_W'(MAX_RES));

    // R4: a spill request holds until done
    a_r4_spill_held: assert property (@(posedge clk) disable iff (rst)
        (spill_req_o && !xfer_done_i) |=> spill_req_o);

    // R5: fills only happen with a single resident frame
    a_r5_fill_at_bottom: assert property (@(posedge clk) disable iff (rst)
        fill_req_o |-> (res_cnt == RES_W'(1)));

    // R6: pointer and frame frozen while stalled with no done
    a_r6_frozen_in_stall: assert property (@(posedge clk) disable iff (rst)
        (stall_o && !xfer_done_i) |=> ($stable(cwp_o) && $stable(xfer_frame_o)));

    // R6: never spill and fill at once
    a_r6_one_request: assert property (@(posedge clk) disable iff (rst)
        !(spill_req_o && fill_req_o));

    // R9: parked means nothing resident and no stall
    a_r9_parked_empty: assert property (@(posedge clk) disable iff (rst)
        saved_valid_o |-> (res_cnt == '0 && !stall_o));

endmodule

bind rwin_ctrl rwin_ctrl_chk #(
    .PTR_W   (PTR_W),
    .RES_W   (RES_W),
    .MAX_RES (MAX_RES)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .call_i        (call_i),
    .switch_out_i  (switch_out_i),
    .xfer_done_i   (xfer_done_i),
    .cwp_o         (cwp_o),
    .spill_req_o   (spill_req_o),
    .fill_req_o    (fill_req_o),
    .xfer_frame_o  (xfer_frame_o),
    .stall_o       (stall_o),
    .saved_valid_o (saved_valid_o),
    .res_cnt       (res_cnt)
);

// File: tb/rwin_ctrl_tb_top.sv
module rwin_ctrl_tb_top;

    localparam int PTR_W   = 4;
    localparam int DEPTH_W = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               call_i = 1'b0, ret_i = 1'b0;
    logic               switch_out_i = 1'b0, switch_in_i = 1'b0;
    logic [DEPTH_W-1:0] restore_depth_i = '0;
    logic               xfer_done_i = 1'b0;
    logic [PTR_W-1:0]   cwp_o, xfer_frame_o;
    logic               spill_req_o, fill_req_o, stall_o, saved_valid_o;
    logic [DEPTH_W-1:0] saved_depth_o;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #10 clk = ~clk;  // 50 MHz

    rwin_ctrl dut_i (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .switch_out_i(switch_out_i), .switch_in_i(switch_in_i),
        .restore_depth_i(restore_depth_i), .xfer_done_i(xfer_done_i),
        .cwp_o(cwp_o), .spill_req_o(spill_req_o), .fill_req_o(fill_req_o),
        .xfer_frame_o(xfer_frame_o), .stall_o(stall_o),
        .saved_valid_o(saved_valid_o), .saved_depth_o(saved_depth_o)
    );

    task automatic chk(input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    // op codes for the table
    localparam logic [1:0] K_CALL = 2'd0, K_RET = 2'd1, K_DONE = 2'd2;

    task automatic pulse(input logic [1:0] k);
        @(negedge clk);
        case (k)
            K_CALL:  call_i = 1'b1;
            K_RET:   ret_i = 1'b1;
            default: xfer_done_i = 1'b1;
        endcase
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b0; xfer_done_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic state_chk(input string tag, input int cwp, input bit s, input bit f);
        chk({tag, " cwp"},   int'(cwp_o), cwp);
        chk({tag, " spill"}, int'(spill_req_o), int'(s));
        chk({tag, " fill"},  int'(fill_req_o), int'(f));
        chk({tag, " stall"}, int'(stall_o), int'(s | f));
    endtask

    // {op[16:15], count[14:10], cwp[9:6], spill[5], fill[4], frame[3:0]}
    localparam logic [16:0] TBL [13] = '{
        {K_CALL, 5'd14, 4'd2,  1'b0, 1'b0, 4'd0},   // R3 R2
        {K_CALL, 5'd1,  4'd2,  1'b1, 1'b0, 4'd0},   // R4 oldest frame
        {K_CALL, 5'd1,  4'd2,  1'b1, 1'b0, 4'd0},   // R6 ignored in stall
        {K_DONE, 5'd1,  4'd1,  1'b0, 1'b0, 4'd0},   // R4 complete
        {K_CALL, 5'd1,  4'd1,  1'b1, 1'b0, 4'd15},  // R4 second spill
        {K_DONE, 5'd1,  4'd0,  1'b0, 1'b0, 4'd0},
        {K_RET,  5'd14, 4'd14, 1'b0, 1'b0, 4'd0},   // R2 returns
        {K_RET,  5'd1,  4'd14, 1'b0, 1'b1, 4'd15},  // R5 fill
        {K_RET,  5'd1,  4'd14, 1'b0, 1'b1, 4'd15},  // R6 ignored in stall
        {K_DONE, 5'd1,  4'd15, 1'b0, 1'b0, 4'd0},   // R5 complete
        {K_RET,  5'd1,  4'd15, 1'b0, 1'b1, 4'd0},   // R5 second fill
        {K_DONE, 5'd1,  4'd0,  1'b0, 1'b0, 4'd0},
        {K_RET,  5'd1,  4'd0,  1'b0, 1'b0, 4'd0}    // R7 empty return
    };

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        state_chk("R1 reset", 0, 1'b0, 1'b0);
        chk("R1 saved_valid", int'(saved_valid_o), 0);

        foreach (TBL[i]) begin
            for (int n = 0; n < int'(TBL[i][14:10]); n++) pulse(TBL[i][16:15]);
            state_chk($sformatf("R2-table row %0d", i), int'(TBL[i][9:6]), TBL[i][5], TBL[i][4]);
            if (TBL[i][5] | TBL[i][4])
                chk($sformatf("R4/R5 row %0d frame", i), int'(xfer_frame_o), int'(TBL[i][3:0]));
        end

        // R1 reset in the middle of a stall
        for (int n = 0; n < 15; n++) pulse(K_CALL);
        chk("R4 pre-reset spill", int'(spill_req_o), 1);
        do_reset();
        state_chk("R1 reset mid-stall", 0, 1'b0, 1'b0);

        // R8 simple switch: 3 calls -> cwp 13, 4 resident
        for (int n = 0; n < 3; n++) pulse(K_CALL);
        @(negedge clk); switch_out_i = 1'b1; call_i = 1'b1;
        @(negedge clk); switch_out_i = 1'b0; call_i = 1'b0;
        state_chk("R8 switch priority", 13, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            chk($sformatf("R8 drain frame %0d", k), int'(xfer_frame_o), (16 - k) % 16);
            pulse(K_DONE);
        end
        state_chk("R9 parked", 13, 1'b0, 1'b0);
        chk("R9 saved_valid", int'(saved_valid_o), 1);
        chk("R9 saved_depth", int'(saved_depth_o), 4);
        pulse(K_CALL);
        pulse(K_RET);
        state_chk("R9 strobes ignored parked", 13, 1'b0, 1'b0);
        chk("R9 still parked", int'(saved_valid_o), 1);

        // R10 restore depth 4
        @(negedge clk); switch_in_i = 1'b1; restore_depth_i = 8'd4;
        @(negedge clk); switch_in_i = 1'b0; restore_depth_i = '0;
        state_chk("R10 load fill", 13, 1'b0, 1'b1);
        chk("R10 load frame", int'(xfer_frame_o), 13);
        chk("R10 unparked", int'(saved_valid_o), 0);
        pulse(K_DONE);
        state_chk("R10 running", 13, 1'b0, 1'b0);
        pulse(K_RET);
        state_chk("R10 return fills", 13, 1'b0, 1'b1);
        chk("R10 return frame", int'(xfer_frame_o), 14);
        pulse(K_DONE);
        state_chk("R10 after fill", 14, 1'b0, 1'b0);

        // R8 deep switch with one frame already in memory
        do_reset();
        for (int n = 0; n < 15; n++) pulse(K_CALL);
        pulse(K_DONE);
        state_chk("R4 deep pre", 1, 1'b0, 1'b0);
        @(negedge clk); switch_out_i = 1'b1;
        @(negedge clk); switch_out_i = 1'b0;
        for (int k = 0; k < 15; k++) begin
            chk($sformatf("R8 deep drain %0d spill", k), int'(spill_req_o), 1);
            chk($sformatf("R8 deep drain %0d frame", k), int'(xfer_frame_o), 15 - k);
            pulse(K_DONE);
        end
        chk("R9 deep saved_valid", int'(saved_valid_o), 1);
        chk("R9 deep saved_depth", int'(saved_depth_o), 16);

        // R10 depth 0 counts as 1: afterwards return is empty
        @(negedge clk); switch_in_i = 1'b1; restore_depth_i = '0;
        @(negedge clk); switch_in_i = 1'b0;
        chk("R10 depth0 fill frame", int'(xfer_frame_o), 1);
        pulse(K_DONE);
        pulse(K_RET);
        state_chk("R10 R7 depth0 return empty", 1, 1'b0, 1'b0);

        ended = 1;
        summary();
        $finish;
    end

endmodule